// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Table with Pending Array

This block holds the per-vector interrupt message table and the pending-bit array for a function that raises message-signalled interrupts. Each of `NUM_VEC` vectors owns a 64-bit message address, a 32-bit message data word and a mask flag. Software reaches the table and the pending array through two separate 32-bit word ports. An upstream bridge splits any 8-byte access into two word accesses. Both ports read combinationally. Writes take effect at the clock edge.

Interrupt sources request pending bits through a set vector, and the delivery logic clears them through a clear vector. Each table write compares the written vector's mask state before and after the write. A vector that goes from masked to unmasked while its pending bit is set has that bit cleared, and the block asks the delivery logic to replay the interrupt on a one-cycle request. A side port returns any vector's current message combinationally, and the mask flags of all vectors are exported as a bus.

Top module: `msgvec_table`

## Requirements
- R1: After synchronous reset, every vector's address and data words read zero and its mask flag is set (vector-control reads 1). All pending bits read zero. `replay_vld` and `mask_chg` are low.
- R2: A table entry spans 16 bytes, and the vector index is the byte address divided by 16. Word offset 0 holds address bits 31:0, offset 4 holds address bits 63:32, offset 8 holds the message data and offset 12 holds vector control. A write is returned by a later read of the same word.
- R3: Only bit 0 of vector control is stored. It is the mask flag, and 1 means masked. All other bits read zero. `vec_masked[v]` follows the stored flag.
- R4: `sel_addr` and `sel_data` show the message address and data of the vector picked by `sel_vec`, combinationally.
- R5: A table access whose vector index is `NUM_VEC` or above reads zero and changes no state.
- R6: A set bit in `pend_set` sets that pending bit at the next edge, and a set bit in `pend_clr` clears it. When both name the same vector in one cycle, the clear wins.
- R7: In the pending array, vector v sits at bit v mod 32 of 32-bit word v/32, which is the same as byte v/8, bit v mod 8, little-endian. The array is rounded up to whole 64-bit units. Bits for vectors that do not exist read zero, and words past the rounded size read zero.
- R8: Writes to the pending-array port change no pending bit.
- R9: A vector-control write that unmasks a vector whose pending bit is set clears that bit at the same edge. In the following cycle `replay_vld` is high for exactly one cycle, with `replay_vec` naming the vector.
- R10: No replay is raised when the unmasked vector has no pending bit set. No replay is raised by a write that leaves the mask state unchanged, whether the vector is masked or unmasked, and the pending bit is then kept.
- R11: `mask_chg[v]` pulses for one cycle after a write that flips vector v's mask flag in either direction. It stays low when the mask flag is rewritten with its current value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Table word write strobe |
| tbl_addr | input | ADDR_W | Table byte address |
| tbl_wdata | input | 32 | Table write data |
| tbl_rdata | output | 32 | Table read data (combinational) |
| pba_we | input | 1 | Pending-array write strobe (discarded) |
| pba_addr | input | PBA_AW | Pending-array byte address |
| pba_wdata | input | 32 | Pending-array write data (discarded) |
| pba_rdata | output | 32 | Pending-array read data (combinational) |
| pend_set | input | NUM_VEC | Per-vector pending set requests |
| pend_clr | input | NUM_VEC | Per-vector pending clear requests |
| sel_vec | input | VSEL_W | Vector picked for the message side port |
| sel_addr | output | 64 | Message address of the picked vector |
| sel_data | output | 32 | Message data of the picked vector |
| vec_masked | output | NUM_VEC | Per-vector mask flag |
| mask_chg | output | NUM_VEC | One-cycle pulse per vector whose mask flipped |
| replay_vld | output | 1 | One-cycle replay request |
| replay_vec | output | VSEL_W | Vector to replay |

## Verification
Several behaviours are checked by assertions on every cycle:
- A replayed vector is always unmasked and its pending bit is already clear (R9).
- Pending-array writes never raise a pending bit (R8).
- Out-of-range table writes leave the mask flags alone (R5).
- Mask flags hold when their entry is not written, and `mask_chg` only follows a real flip (R11).
- Set requests land unless a clear or a replay clear overrides them (R6).
- Every vector is masked right after reset (R1).

The word layout, the vector-control bits that read zero, the side-port contents and the pending-array word packing and padding are only visible through readback values, so the bench's scenarios show them. The same holds for the cases where no replay is raised, such as an unchanged mask or an unmask with nothing pending.

// File: rtl/msgvec_pkg.sv
package msgvec_pkg;

    localparam int ENTRY_BYTES = 16;

    typedef enum logic [1:0] {
        W_ADDR_LO = 2'd0,
        W_ADDR_HI = 2'd1,
        W_DATA    = 2'd2,
        W_CTRL    = 2'd3
    } entry_word_e;

    typedef struct packed {
        logic [31:0] addr_hi;
        logic [31:0] addr_lo;
        logic [31:0] data;
        logic        mask;
    } entry_t;

    typedef struct packed {
        logic [63:0] addr;
        logic [31:0] data;
    } msg_t;

    // Pending array rounded up to whole 64-bit units, counted in 32-bit words
    function automatic int pba_words(input int nvec);
        return ((nvec + 63) / 64) * 2;
    endfunction

endpackage

// File: rtl/msgvec_entry.sv
module msgvec_entry
    import msgvec_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  entry_word_e wr_word,
    input  logic [31:0] wr_data,
    input  entry_word_e rd_word,
    output logic [31:0] rd_data,
    output logic        masked,
    output msg_t        msg,
    output logic        unmask_now,
    output logic        mask_chg
);

    entry_t ent;
    logic   ctrl_wr;

    assign ctrl_wr = wr_en && (wr_word == W_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            ent      <= '0;
            ent.mask <= 1'b1;
            mask_chg <= 1'b0;
        end else begin
            mask_chg <= ctrl_wr && (wr_data[0] != ent.mask);
            if (wr_en) begin
                case (wr_word)
                    W_ADDR_LO: ent.addr_lo <= wr_data;
                    W_ADDR_HI: ent.addr_hi <= wr_data;
                    W_DATA:    ent.data    <= wr_data;
                    default:   ent.mask    <= wr_data[0];
                endcase
            end
        end
    end

    always_comb begin
        case (rd_word)
            W_ADDR_LO: rd_data = ent.addr_lo;
            W_ADDR_HI: rd_data = ent.addr_hi;
            W_DATA:    rd_data = ent.data;
            default:   rd_data = {31'd0, ent.mask};
        endcase
    end

    assign masked     = ent.mask;
    assign msg.addr   = {ent.addr_hi, ent.addr_lo};
    assign msg.data   = ent.data;
    assign unmask_now = ctrl_wr && ent.mask && !wr_data[0];

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(masked)); // R3

    AST_CHG_IS_FLIP: assert property (@(posedge clk) disable iff (rst)
        mask_chg |-> (masked != $past(masked))); // R11

endmodule

// File: rtl/msgvec_pend.sv
module msgvec_pend #(
    parameter int NUM_VEC   = 8,
    parameter int PBA_WORDS = 2,
    parameter int IDX_W     = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_VEC-1:0] set_req,
    input  logic [NUM_VEC-1:0] clr_req,
    input  logic [NUM_VEC-1:0] rpl_clr,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [NUM_VEC-1:0] pend,
    output logic [31:0]        rd_data
);

    localparam int PBA_BITS = PBA_WORDS * 32;

    logic [NUM_VEC-1:0]  pend_q;
    logic [PBA_BITS-1:0] padded;

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= (pend_q | set_req) & ~(clr_req | rpl_clr);
    end

    always_comb begin
        padded = '0;
        padded[NUM_VEC-1:0] = pend_q;
    end

    always_comb begin
        rd_data = '0;
        for (int w = 0; w < PBA_WORDS; w++) begin
            if (rd_idx == IDX_W'(w)) rd_data = padded[w*32 +: 32];
        end
    end

    assign pend = pend_q;

    AST_SET_LANDS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_q & $past(set_req & ~clr_req & ~rpl_clr))
                  == $past(set_req & ~clr_req & ~rpl_clr))); // R6

    AST_CLR_WINS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_q & $past(clr_req)) == '0)); // R6

endmodule

// File: rtl/msgvec_table.sv
module msgvec_table
    import msgvec_pkg::*;
#(
    parameter int NUM_VEC = 8,
    parameter int ADDR_W  = 12,
    parameter int PBA_AW  = 8,
    parameter int VSEL_W  = $clog2(NUM_VEC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tbl_we,
    input  logic [ADDR_W-1:0]  tbl_addr,
    input  logic [31:0]        tbl_wdata,
    output logic [31:0]        tbl_rdata,
    input  logic               pba_we,
    input  logic [PBA_AW-1:0]  pba_addr,
    input  logic [31:0]        pba_wdata,
    output logic [31:0]        pba_rdata,
    input  logic [NUM_VEC-1:0] pend_set,
    input  logic [NUM_VEC-1:0] pend_clr,
    input  logic [VSEL_W-1:0]  sel_vec,
    output logic [63:0]        sel_addr,
    output logic [31:0]        sel_data,
    output logic [NUM_VEC-1:0] vec_masked,
    output logic [NUM_VEC-1:0] mask_chg,
    output logic               replay_vld,
    output logic [VSEL_W-1:0]  replay_vec
);

    localparam int IDX_W     = ADDR_W - $clog2(ENTRY_BYTES);
    localparam int PBA_WORDS = pba_words(NUM_VEC);
    localparam int PBA_IDX_W = PBA_AW - 2;

    logic [IDX_W-1:0]   tbl_idx;
    entry_word_e        tbl_word;
    logic               in_range;
    logic [NUM_VEC-1:0] ent_wr;
    logic [NUM_VEC-1:0] unmask_now;
    logic [NUM_VEC-1:0] rpl_clr;
    logic [NUM_VEC-1:0] pend;
    logic [31:0]        ent_rd [NUM_VEC];
    msg_t               ent_msg [NUM_VEC];
    logic [VSEL_W-1:0]  rpl_idx;
    logic               port_bits_unused;

    assign tbl_idx  = tbl_addr[ADDR_W-1:4];
    assign tbl_word = entry_word_e'(tbl_addr[3:2]);
    assign in_range = tbl_idx < IDX_W'(NUM_VEC);

    // Pending-array writes are discarded; byte lanes below a word are not decoded
    assign port_bits_unused = pba_we ^ (^pba_wdata) ^ (^pba_addr[1:0]) ^ (^tbl_addr[1:0]);

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_ent
        assign ent_wr[v] = tbl_we && in_range && (tbl_idx == IDX_W'(v));
        msgvec_entry u_ent (
            .clk        (clk),
            .rst        (rst),
            .wr_en      (ent_wr[v]),
            .wr_word    (tbl_word),
            .wr_data    (tbl_wdata),
            .rd_word    (tbl_word),
            .rd_data    (ent_rd[v]),
            .masked     (vec_masked[v]),
            .msg        (ent_msg[v]),
            .unmask_now (unmask_now[v]),
            .mask_chg   (mask_chg[v])
        );
    end

    always_comb begin
        tbl_rdata = '0;
        for (int v = 0; v < NUM_VEC; v++) begin
            if (in_range && tbl_idx == IDX_W'(v)) tbl_rdata = ent_rd[v];
        end
    end

    always_comb begin
        sel_addr = '0;
        sel_data = '0;
        for (int v = 0; v < NUM_VEC; v++) begin
            if (sel_vec == VSEL_W'(v)) begin
                sel_addr = ent_msg[v].addr;
                sel_data = ent_msg[v].data;
            end
        end
    end

    // Only one entry is written per cycle, so at most one bit is set here
    assign rpl_clr = unmask_now & pend;

    always_comb begin
        rpl_idx = '0;
        for (int v = 0; v < NUM_VEC; v++) begin
            if (rpl_clr[v]) rpl_idx = VSEL_W'(v);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            replay_vld <= 1'b0;
            replay_vec <= '0;
        end else begin
            replay_vld <= |rpl_clr;
            replay_vec <= rpl_idx;
        end
    end

    msgvec_pend #(
        .NUM_VEC   (NUM_VEC),
        .PBA_WORDS (PBA_WORDS),
        .IDX_W     (PBA_IDX_W)
    ) u_pend (
        .clk     (clk),
        .rst     (rst),
        .set_req (pend_set),
        .clr_req (pend_clr),
        .rpl_clr (rpl_clr),
        .rd_idx  (pba_addr[PBA_AW-1:2]),
        .pend    (pend),
        .rd_data (pba_rdata)
    );

    AST_RESET_MASKED: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (&vec_masked)); // R1

    AST_OOR_DROP: assert property (@(posedge clk) disable iff (rst)
        (tbl_we && !in_range) |=> $stable(vec_masked)); // R5

    AST_PBA_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (pba_we && pend_set == '0) |=> ((pend & ~$past(pend)) == '0)); // R8

    AST_REPLAY_UNMASKED: assert property (@(posedge clk) disable iff (rst)
        replay_vld |-> !vec_masked[replay_vec]); // R9

    AST_REPLAY_PEND_CLR: assert property (@(posedge clk) disable iff (rst)
        replay_vld |-> !pend[replay_vec]); // R9

endmodule

// File: tb/tb_msgvec_table.sv
module tb_msgvec_table;

    localparam int NV = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tbl_we = 1'b0;
    logic [11:0] tbl_addr = '0;
    logic [31:0] tbl_wdata = '0;
    logic [31:0] tbl_rdata;
    logic        pba_we = 1'b0;
    logic [7:0]  pba_addr = '0;
    logic [31:0] pba_wdata = '0;
    logic [31:0] pba_rdata;
    logic [NV-1:0] pend_set = '0;
    logic [NV-1:0] pend_clr = '0;
    logic [2:0]  sel_vec = '0;
    logic [63:0] sel_addr;
    logic [31:0] sel_data;
    logic [NV-1:0] vec_masked;
    logic [NV-1:0] mask_chg;
    logic        replay_vld;
    logic [2:0]  replay_vec;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    msgvec_table #(.NUM_VEC(NV), .ADDR_W(12), .PBA_AW(8)) dut (
        .clk(clk), .rst(rst),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata), .tbl_rdata(tbl_rdata),
        .pba_we(pba_we), .pba_addr(pba_addr), .pba_wdata(pba_wdata), .pba_rdata(pba_rdata),
        .pend_set(pend_set), .pend_clr(pend_clr),
        .sel_vec(sel_vec), .sel_addr(sel_addr), .sel_data(sel_data),
        .vec_masked(vec_masked), .mask_chg(mask_chg),
        .replay_vld(replay_vld), .replay_vec(replay_vec)
    );

    // {req, addr, write data, expected readback}
    localparam logic [79:0] VECS [0:8] = '{
        {4'd2, 12'h000, 32'hFEE0_0000, 32'hFEE0_0000}, // R2 vec0 address low
        {4'd2, 12'h004, 32'h0000_0001, 32'h0000_0001}, // R2 vec0 address high
        {4'd2, 12'h008, 32'h0000_0041, 32'h0000_0041}, // R2 vec0 data
        {4'd2, 12'h078, 32'hA5A5_5A5A, 32'hA5A5_5A5A}, // R2 vec7 data
        {4'd3, 12'h07C, 32'hFFFF_FFFF, 32'h0000_0001}, // R3 only mask bit kept
        {4'd3, 12'h07C, 32'hFFFF_FFFE, 32'h0000_0000}, // R3 unmask vec7
        {4'd5, 12'h080, 32'hDEAD_BEEF, 32'h0000_0000}, // R5 index 8 out of range
        {4'd5, 12'h0FC, 32'h0000_1234, 32'h0000_0000}, // R5 far out of range
        {4'd2, 12'h054, 32'h8000_0000, 32'h8000_0000}  // R2 vec5 address high
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tbl_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        tbl_we = 1'b1; tbl_addr = a; tbl_wdata = d;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic tbl_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        tbl_addr = a;
        #1 d = tbl_rdata;
    endtask

    task automatic pba_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        pba_addr = a;
        #1 d = pba_rdata;
    endtask

    task automatic pend_pulse(input logic [NV-1:0] s, input logic [NV-1:0] c);
        @(negedge clk);
        pend_set = s; pend_clr = c;
        @(negedge clk);
        pend_set = '0; pend_clr = '0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 vec_masked", 64'(vec_masked), 64'hFF);
        chk("R1 replay_vld", 64'(replay_vld), 64'h0);
        chk("R1 mask_chg", 64'(mask_chg), 64'h0);
        for (int v = 0; v < NV; v++) begin
            tbl_rd(12'((v * 16) + 12), rd);
            chk("R1 ctrl", 64'(rd), 64'h1);
            tbl_rd(12'(v * 16), rd);
            chk("R1 addr low", 64'(rd), 64'h0);
        end
        pba_rd(8'h00, rd);
        chk("R1 pending", 64'(rd), 64'h0);

        // Vector table walk: R2 R3 R5
        for (int i = 0; i < 9; i++) begin
            tbl_wr(VECS[i][75:64], VECS[i][63:32]);
            tbl_rd(VECS[i][75:64], rd);
            n_chk++;
            if (rd !== VECS[i][31:0]) begin
                n_bad++;
                $display("FAIL R%0d vector %0d: actual %h expected %h",
                         VECS[i][79:76], i, rd, VECS[i][31:0]);
            end
        end
        chk("R3 vec_masked after unmask vec7", 64'(vec_masked), 64'h7F);
        chk("R5 vec_masked unchanged", 64'(vec_masked), 64'h7F);

        // R4 side port
        @(negedge clk); sel_vec = 3'd0;
        #1 chk("R4 sel_addr vec0", sel_addr, 64'h0000_0001_FEE0_0000);
        chk("R4 sel_data vec0", 64'(sel_data), 64'h41);
        @(negedge clk); sel_vec = 3'd5;
        #1 chk("R4 sel_addr vec5", sel_addr, 64'h8000_0000_0000_0000);
        chk("R4 sel_data vec5", 64'(sel_data), 64'h0);

        // R6 set, then clear beating set
        pend_pulse(8'h28, 8'h00);
        pba_rd(8'h00, rd);
        chk("R6 set", 64'(rd), 64'h28);
        pend_pulse(8'h0A, 8'h08);
        pba_rd(8'h00, rd);
        chk("R6 clear wins", 64'(rd), 64'h22);

        // R7 padding and words past the array
        pba_rd(8'h04, rd);
        chk("R7 padding word", 64'(rd), 64'h0);
        pba_rd(8'h08, rd);
        chk("R7 beyond array", 64'(rd), 64'h0);

        // R8 writes to the pending array
        @(negedge clk);
        pba_we = 1'b1; pba_addr = 8'h00; pba_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        pba_we = 1'b0;
        pba_rd(8'h00, rd);
        chk("R8 pending unchanged", 64'(rd), 64'h22);

        // R9 unmask vec5 with pending set
        tbl_wr(12'h05C, 32'h0);
        chk("R9 replay_vld", 64'(replay_vld), 64'h1);
        chk("R9 replay_vec", 64'(replay_vec), 64'h5);
        chk("R11 mask_chg unmask", 64'(mask_chg), 64'h20);
        pba_rd(8'h00, rd);
        chk("R9 pending cleared", 64'(rd), 64'h02);
        chk("R9 replay one cycle", 64'(replay_vld), 64'h0);

        // R10 rewrite masked vec1 with mask set, pending kept
        tbl_wr(12'h01C, 32'h1);
        chk("R10 no replay masked rewrite", 64'(replay_vld), 64'h0);
        chk("R11 no mask_chg", 64'(mask_chg), 64'h0);
        pba_rd(8'h00, rd);
        chk("R10 pending kept", 64'(rd), 64'h02);

        // R10 unmasked vec7 rewritten unmasked with pending set
        pend_pulse(8'h80, 8'h00);
        tbl_wr(12'h07C, 32'h0);
        chk("R10 no replay unmasked rewrite", 64'(replay_vld), 64'h0);
        chk("R11 no mask_chg unmasked rewrite", 64'(mask_chg), 64'h0);

        // R11 mask vec7 again
        tbl_wr(12'h07C, 32'h1);
        chk("R11 mask_chg mask", 64'(mask_chg), 64'h80);
        chk("R10 no replay on mask", 64'(replay_vld), 64'h0);
        pba_rd(8'h00, rd);
        chk("R10 pending after mask", 64'(rd), 64'h82);

        // R10 unmask vec6 with nothing pending
        tbl_wr(12'h06C, 32'h0);
        chk("R10 no replay without pending", 64'(replay_vld), 64'h0);
        chk("R11 mask_chg vec6", 64'(mask_chg), 64'h40);

        // R1 reset again clears everything
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk("R1 re-reset masked", 64'(vec_masked), 64'hFF);
        pba_rd(8'h00, rd);
        chk("R1 re-reset pending", 64'(rd), 64'h0);
        tbl_rd(12'h000, rd);
        chk("R1 re-reset addr", 64'(rd), 64'h0);

        done = 1;
        finish_run();
    end

endmodule